// File: doc/BRIEF.md
# Unaligned Bit-Run Copier

This block moves a run of bits from one byte-wide memory into another. Each end of the run can start at any bit, with no link between the two sub-byte offsets. A command gives a source bit offset, a destination bit offset and a bit count. The block then walks the destination one byte at a time. It slides source bytes through a two-byte window and shifts them into place. Only bytes that the run covers in part are read back and merged, so the bits outside the run keep their old values.

Both memories use plain byte ports. A read has a fixed latency of one cycle: the data appears in the cycle after the enable. Nothing stalls, so the memories must always answer on time. The command pins are plain control: a one-cycle `start`, a level `busy` and a one-cycle `done`. The two regions must not overlap.

Top module: `bitcopy_engine`

## Requirements
- R1: A bit offset names byte `offset >> 3` and bit `offset & 7`. Bit k of byte b is global bit 8b+k, and bit 0 is the LSB. Copied bit i moves from source global bit `src_off + i` to destination global bit `dst_off + i`.
- R2: The source and destination bit positions are independent. Results are correct when the source bit is below, equal to or above the destination bit.
- R3: In the first destination byte, every bit below the destination bit position keeps its old value.
- R4: In the last destination byte, every bit above the last copied bit keeps its old value. This also holds when the first and last byte are the same byte.
- R5: A bit count of zero writes nothing, and `done` is high in the cycle after `start`.
- R6: A destination byte the run covers only in part is read first, then written with merged data in the next cycle at the same address. A fully covered byte is written with no read. The read and write enables are never high together.
- R7: `done` is high for exactly one cycle, in the cycle after the last write. `busy` is high from the cycle after an accepted `start` up to and including the `done` cycle. While `busy` is low, no memory enable is active.
- R8: A `start` while `busy` is high has no effect on the running copy, and it does not queue a second one.
- R9: Each destination byte from `dst_off>>3` to `(dst_off+count-1)>>3` is written exactly once, in ascending address order. No other destination byte is written.
- R10: When both offsets are byte-aligned and the count is a multiple of 8, the destination bytes become exact copies of the source bytes and the destination is never read.
- R11: The block reads exactly the source bytes that hold copied bits. Each is read once, in ascending order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Command strobe, accepted only while idle |
| src_off | input | 15 | Source start, as a bit address |
| dst_off | input | 15 | Destination start, as a bit address |
| bit_count | input | 16 | Number of bits to copy |
| busy | output | 1 | A command is in progress |
| done | output | 1 | One-cycle completion pulse |
| src_rd_en | output | 1 | Source byte read enable |
| src_addr | output | 12 | Source byte address |
| src_rd_data | input | 8 | Source read data, one cycle after the enable |
| dst_rd_en | output | 1 | Destination byte read enable |
| dst_wr_en | output | 1 | Destination byte write enable |
| dst_addr | output | 12 | Destination byte address, shared by read and write |
| dst_wr_data | output | 8 | Destination write data |
| dst_rd_data | input | 8 | Destination read data, one cycle after the enable |

## Verification
A stale or lost window byte shows as wrong data in the very next destination write. A wrong shift or edge mask corrupts the first or last written byte of the run. A bad byte count shows before `done` rises, as a missing or extra write, or as a source read outside the run. A state machine that leaves a read-modify-write pair unfinished shows one cycle later, as a read with no write behind it at the same address.

// File: rtl/bitcopy_pkg.sv
package bitcopy_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PRE,
    ST_FETCH,
    ST_WRITE,
    ST_DONE
  } bc_state_e;

  // Per-command geometry derived from the two offsets and the count
  typedef struct packed {
    logic [2:0] sbit;   // source bit within its first byte
    logic [2:0] dbit;   // destination bit within its first byte
    logic [2:0] shift;  // window shift, (sbit - dbit) mod 8
    logic [2:0] tail;   // bit position of the last copied destination bit
    logic       pre;    // a source byte must be loaded before the first write
  } bc_geom_t;

endpackage

// File: rtl/bitcopy_plan.sv
module bitcopy_plan
  import bitcopy_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int CNT_W  = 16
) (
  input  logic [ADDR_W+2:0] src_off,
  input  logic [ADDR_W+2:0] dst_off,
  input  logic [CNT_W-1:0]  bit_count,
  output logic [ADDR_W-1:0] src_byte,
  output logic [ADDR_W-1:0] dst_byte,
  output logic [CNT_W-1:0]  src_bytes,
  output logic [CNT_W-1:0]  dst_bytes,
  output bc_geom_t          geom
);
  localparam int SUM_W = CNT_W + 4;

  logic [SUM_W-1:0] s_sum;
  logic [SUM_W-1:0] d_sum;

  always_comb begin
    src_byte   = src_off[ADDR_W+2:3];
    dst_byte   = dst_off[ADDR_W+2:3];
    s_sum      = SUM_W'(bit_count) + SUM_W'(src_off[2:0]) + SUM_W'(7);
    d_sum      = SUM_W'(bit_count) + SUM_W'(dst_off[2:0]) + SUM_W'(7);
    src_bytes  = s_sum[CNT_W+2:3];
    dst_bytes  = d_sum[CNT_W+2:3];
    geom.sbit  = src_off[2:0];
    geom.dbit  = dst_off[2:0];
    geom.shift = src_off[2:0] - dst_off[2:0];
    geom.tail  = dst_off[2:0] + bit_count[2:0] - 3'd1;
    geom.pre   = (src_off[2:0] >= dst_off[2:0]);
  end
endmodule

// File: rtl/bitcopy_mask.sv
module bitcopy_mask (
  input  logic [2:0] lo_bit,
  input  logic [2:0] hi_bit,
  input  logic       is_first,
  input  logic       is_last,
  output logic [7:0] mask,
  output logic       partial
);
  for (genvar p = 0; p < 8; p++) begin : g_bit
    assign mask[p] = (!is_first || (3'(p) >= lo_bit)) &&
                     (!is_last  || (3'(p) <= hi_bit));
  end
  assign partial = ~&mask;
endmodule

// File: rtl/bitcopy_align.sv
module bitcopy_align (
  input  logic [7:0] lo,
  input  logic [7:0] hi,
  input  logic [2:0] shift,
  input  logic [7:0] mask,
  input  logic [7:0] old,
  output logic [7:0] merged
);
  logic [15:0] win;
  assign win    = {hi, lo} >> shift;
  assign merged = (win[7:0] & mask) | (old & ~mask);
endmodule

// File: rtl/bitcopy_engine.sv
module bitcopy_engine
  import bitcopy_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [ADDR_W+2:0] src_off,
  input  logic [ADDR_W+2:0] dst_off,
  input  logic [CNT_W-1:0]  bit_count,
  output logic              busy,
  output logic              done,
  output logic              src_rd_en,
  output logic [ADDR_W-1:0] src_addr,
  input  logic [7:0]        src_rd_data,
  output logic              dst_rd_en,
  output logic              dst_wr_en,
  output logic [ADDR_W-1:0] dst_addr,
  output logic [7:0]        dst_wr_data,
  input  logic [7:0]        dst_rd_data
);
  bc_state_e         state;
  logic [ADDR_W-1:0] src_base, dst_base;
  logic [CNT_W-1:0]  src_total, dst_total;
  logic [CNT_W-1:0]  j_cnt, s_idx;
  bc_geom_t          geom_r;
  logic [7:0]        lo_q;
  logic              lo_pend, hi_ok;

  logic [ADDR_W-1:0] p_src_byte, p_dst_byte;
  logic [CNT_W-1:0]  p_src_bytes, p_dst_bytes;
  bc_geom_t          p_geom;

  logic [7:0] mask, hi_byte, merged;
  logic       partial, is_first, is_last, fetch_src;

  bitcopy_plan #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_plan (
    .src_off   (src_off),
    .dst_off   (dst_off),
    .bit_count (bit_count),
    .src_byte  (p_src_byte),
    .dst_byte  (p_dst_byte),
    .src_bytes (p_src_bytes),
    .dst_bytes (p_dst_bytes),
    .geom      (p_geom)
  );

  assign is_first = (j_cnt == '0);
  assign is_last  = (j_cnt == dst_total - CNT_W'(1));

  bitcopy_mask u_mask (
    .lo_bit   (geom_r.dbit),
    .hi_bit   (geom_r.tail),
    .is_first (is_first),
    .is_last  (is_last),
    .mask     (mask),
    .partial  (partial)
  );

  assign hi_byte = hi_ok ? src_rd_data : 8'h00;

  bitcopy_align u_align (
    .lo     (lo_q),
    .hi     (hi_byte),
    .shift  (geom_r.shift),
    .mask   (mask),
    .old    (dst_rd_data),
    .merged (merged)
  );

  assign fetch_src   = (state == ST_FETCH) && (s_idx < src_total);
  assign src_rd_en   = (state == ST_PRE) || fetch_src;
  assign src_addr    = src_base + ADDR_W'(s_idx);
  assign dst_addr    = dst_base + ADDR_W'(j_cnt);
  assign dst_rd_en   = (state == ST_FETCH) && partial;
  assign dst_wr_en   = (state == ST_WRITE);
  assign dst_wr_data = merged;
  assign busy        = (state != ST_IDLE);
  assign done        = (state == ST_DONE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      src_base  <= '0;
      dst_base  <= '0;
      src_total <= '0;
      dst_total <= '0;
      geom_r    <= '0;
      j_cnt     <= '0;
      s_idx     <= '0;
      lo_q      <= '0;
      lo_pend   <= 1'b0;
      hi_ok     <= 1'b0;
    end else begin
      unique case (state)
        ST_IDLE: begin
          if (start) begin
            src_base  <= p_src_byte;
            dst_base  <= p_dst_byte;
            src_total <= p_src_bytes;
            dst_total <= p_dst_bytes;
            geom_r    <= p_geom;
            j_cnt     <= '0;
            s_idx     <= '0;
            lo_q      <= '0;
            lo_pend   <= 1'b0;
            hi_ok     <= 1'b0;
            if (bit_count == '0)  state <= ST_DONE;
            else if (p_geom.pre)  state <= ST_PRE;
            else                  state <= ST_FETCH;
          end
        end
        ST_PRE: begin
          s_idx   <= s_idx + CNT_W'(1);
          lo_pend <= 1'b1;
          state   <= ST_FETCH;
        end
        ST_FETCH: begin
          if (lo_pend) begin
            lo_q    <= src_rd_data;
            lo_pend <= 1'b0;
          end
          hi_ok <= fetch_src;
          if (fetch_src) s_idx <= s_idx + CNT_W'(1);
          state <= ST_WRITE;
        end
        ST_WRITE: begin
          lo_q  <= hi_byte;
          j_cnt <= j_cnt + CNT_W'(1);
          state <= is_last ? ST_DONE : ST_FETCH;
        end
        ST_DONE: state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/bitcopy_checker.sv
module bitcopy_checker #(
  parameter int ADDR_W = 12,
  parameter int CNT_W  = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic [CNT_W-1:0]  bit_count,
  input logic              busy,
  input logic              done,
  input logic              src_rd_en,
  input logic [ADDR_W-1:0] src_addr,
  input logic              dst_rd_en,
  input logic              dst_wr_en,
  input logic [ADDR_W-1:0] dst_addr
);
  logic              wr_seen, rd_seen;
  logic [ADDR_W-1:0] last_wr, last_rd;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_seen <= 1'b0;
      rd_seen <= 1'b0;
      last_wr <= '0;
      last_rd <= '0;
    end else if (start && !busy) begin
      wr_seen <= 1'b0;
      rd_seen <= 1'b0;
    end else begin
      if (dst_wr_en) begin
        wr_seen <= 1'b1;
        last_wr <= dst_addr;
      end
      if (src_rd_en) begin
        rd_seen <= 1'b1;
        last_rd <= src_addr;
      end
    end
  end

  assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  assert_done_release_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !busy);
  assert_idle_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !(src_rd_en || dst_rd_en || dst_wr_en));
  assert_zero_count_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && bit_count == '0) |=> (done && !dst_wr_en));
  assert_rmw_pair_R6: assert property (@(posedge clk) disable iff (!rst_n)
    dst_rd_en |=> (dst_wr_en && dst_addr == $past(dst_addr)));
  assert_rd_wr_excl_R6: assert property (@(posedge clk) disable iff (!rst_n)
    dst_wr_en |-> !dst_rd_en);
  assert_dst_ascend_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (dst_wr_en && wr_seen) |-> (dst_addr == last_wr + ADDR_W'(1)));
  assert_src_ascend_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (src_rd_en && rd_seen) |-> (src_addr == last_rd + ADDR_W'(1)));
  assert_start_ignored_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (start && busy && !done) |=> busy);
endmodule

bind bitcopy_engine bitcopy_checker #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .start     (start),
  .bit_count (bit_count),
  .busy      (busy),
  .done      (done),
  .src_rd_en (src_rd_en),
  .src_addr  (src_addr),
  .dst_rd_en (dst_rd_en),
  .dst_wr_en (dst_wr_en),
  .dst_addr  (dst_addr)
);

// File: tb/sim_bitcopy_engine.sv
module sim_bitcopy_engine;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W     = 12;
  localparam int CNT_W      = 16;
  localparam int MEM_N      = 1 << ADDR_W;
  localparam int CMD_LIMIT  = 20000;
  localparam int DBASE      = 2048 * 8;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              start = 1'b0;
  logic [ADDR_W+2:0] src_off = '0;
  logic [ADDR_W+2:0] dst_off = '0;
  logic [CNT_W-1:0]  bit_count = '0;
  logic              busy, done;
  logic              src_rd_en, dst_rd_en, dst_wr_en;
  logic [ADDR_W-1:0] src_addr, dst_addr;
  logic [7:0]        src_q = 8'h00;
  logic [7:0]        dst_q = 8'h00;
  logic [7:0]        dst_wr_data;

  logic [7:0] smem  [MEM_N];
  logic [7:0] dmem  [MEM_N];
  logic [7:0] dexp  [MEM_N];
  logic [7:0] dorig [MEM_N];

  int n_srd = 0;
  int n_drd = 0;
  int n_dwr = 0;
  int checks = 0;
  int fails = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  bitcopy_engine #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u0 (
    .clk         (clk),
    .rst_n       (rst_n),
    .start       (start),
    .src_off     (src_off),
    .dst_off     (dst_off),
    .bit_count   (bit_count),
    .busy        (busy),
    .done        (done),
    .src_rd_en   (src_rd_en),
    .src_addr    (src_addr),
    .src_rd_data (src_q),
    .dst_rd_en   (dst_rd_en),
    .dst_wr_en   (dst_wr_en),
    .dst_addr    (dst_addr),
    .dst_wr_data (dst_wr_data),
    .dst_rd_data (dst_q)
  );

  task automatic check(input bit ok, input string req, input int got, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: got %0h expected %0h", req, got, exp);
    end
  endtask

  task automatic run_cmd(input int so, input int dof, input int n, input bit intrude);
    int sbit, dbit, nd, ns, npart, cyc, bad, first_bad, hb, tb, tbit;
    logic [7:0] keep;
    sbit = so % 8;
    dbit = dof % 8;
    nd   = (n == 0) ? 0 : (dbit + n + 7) / 8;
    ns   = (n == 0) ? 0 : (sbit + n + 7) / 8;
    if (n == 0) npart = 0;
    else if (nd == 1) npart = (dbit == 0 && ((dbit + n) % 8) == 0) ? 0 : 1;
    else npart = ((dbit != 0) ? 1 : 0) + ((((dbit + n) % 8) != 0) ? 1 : 0);
    for (int i = 0; i < MEM_N; i++) begin
      dorig[i] = dmem[i];
      dexp[i]  = dmem[i];
    end
    for (int i = 0; i < n; i++) begin
      int sb, db;
      sb = so + i;
      db = dof + i;
      dexp[db / 8][db % 8] = smem[sb / 8][sb % 8];
    end
    @(negedge clk);
    n_srd = 0; n_drd = 0; n_dwr = 0;
    src_off = (ADDR_W+3)'(so);
    dst_off = (ADDR_W+3)'(dof);
    bit_count = CNT_W'(n);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    cyc = 1;
    while (!done && cyc < CMD_LIMIT) begin
      @(negedge clk);
      cyc++;
      if (intrude && cyc == 15) begin
        src_off = (ADDR_W+3)'(so + 8);
        dst_off = (ADDR_W+3)'(dof + 16);
        bit_count = CNT_W'(9);
        start = 1'b1;
      end else if (intrude && cyc == 16) begin
        start = 1'b0;
      end
    end
    start = 1'b0;
    check(done, "R7 done never rose (watchdog)", cyc, 0);
    if (!done) return;
    if (n == 0) check(cyc == 1, "R5 zero count done latency", cyc, 1);
    @(negedge clk);
    check(!done && !busy, "R7 done single pulse and busy release", {done, busy}, 0);
    bad = 0; first_bad = -1;
    for (int i = 0; i < MEM_N; i++)
      if (dmem[i] !== dexp[i]) begin
        bad++;
        if (first_bad < 0) first_bad = i;
      end
    if (first_bad >= 0)
      check(0, "R1 R2 R9 destination contents", dmem[first_bad], dexp[first_bad]);
    else
      check(1, "R1 R2 R9 destination contents", 0, 0);
    check(n_dwr == nd, "R9 R5 write count", n_dwr, nd);
    check(n_drd == npart, "R6 R10 destination read count", n_drd, npart);
    check(n_srd == ns, "R11 source read count", n_srd, ns);
    if (n > 0 && dbit != 0) begin
      hb = dof / 8;
      keep = 8'((1 << dbit) - 1);
      check((dmem[hb] & keep) == (dorig[hb] & keep), "R3 head bits kept",
            dmem[hb] & keep, dorig[hb] & keep);
    end
    if (n > 0 && ((dof + n) % 8) != 0) begin
      tb   = (dof + n - 1) / 8;
      tbit = (dof + n - 1) % 8;
      keep = 8'(8'hFF << (tbit + 1));
      check((dmem[tb] & keep) == (dorig[tb] & keep), "R4 tail bits kept",
            dmem[tb] & keep, dorig[tb] & keep);
    end
  endtask

  initial begin
    fork
      begin : main_seq
        int dummy;
        dummy = $urandom(32'h5EED_0B17);
        for (int i = 0; i < MEM_N; i++) begin
          smem[i] = 8'($urandom);
          dmem[i] = 8'($urandom);
        end
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(!busy && !done && !src_rd_en && !dst_rd_en && !dst_wr_en,
              "R7 reset state idle", {busy, done, src_rd_en, dst_rd_en, dst_wr_en}, 0);
        run_cmd(10, DBASE + 3, 0, 0);              // R5 zero count
        run_cmd(5, DBASE + 8 * 4 + 6, 1, 0);       // single bit, R3 R4
        run_cmd(3, DBASE + 8 * 8 + 2, 3, 0);       // head and tail in one byte, R4
        run_cmd(8 * 16, DBASE + 8 * 52, 64, 0);    // R10 aligned copy
        run_cmd(8 * 30 + 6, DBASE + 8 * 70 + 1, 37, 0);  // R2 sbit above dbit
        run_cmd(8 * 40 + 1, DBASE + 8 * 90 + 7, 50, 0);  // R2 sbit below dbit
        run_cmd(8 * 50 + 3, DBASE + 8 * 110 + 5, 8, 0);  // one unaligned byte
        run_cmd(8 * 60 + 2, DBASE + 8 * 130 + 2, 4000, 0); // long, equal bits
        run_cmd(8 * 700 + 4, DBASE + 8 * 800 + 1, 400, 1); // R8 start while busy
        for (int k = 0; k < 80; k++) begin
          int so, dof, n;
          so  = int'($urandom % (2000 * 8));
          dof = DBASE + int'($urandom % (1900 * 8));
          n   = int'($urandom % 700);
          run_cmd(so, dof, n, 0);
        end
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
      end
      begin : mem_model
        forever begin
          @(posedge clk);
          if (src_rd_en) begin
            src_q <= smem[src_addr];
            n_srd <= n_srd + 1;
          end
          if (dst_rd_en) begin
            dst_q <= dmem[dst_addr];
            n_drd <= n_drd + 1;
          end
          if (dst_wr_en) begin
            dmem[dst_addr] <= dst_wr_data;
            n_dwr <= n_dwr + 1;
          end
        end
      end
      begin : watchdog
        repeat (190000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL R7 global watchdog expired: got 1 expected 0");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
      end
    join_any
  end
endmodule